// File: doc/BRIEF.md
# Hub Link Controller Register Front-End

This block sits behind one upstream slave port of a hub that fans out to as many as eight downstream serial links. It takes simple valid/ready requests that carry a 32-bit address, a write enable and 32-bit data, and answers each one on a response channel with read data and an error flag. The address space has two parts. Addresses below 0x80000 reach a small bank of control registers: mode, delay, per-link enable, plug level, port reset, bridge reset, error status and error control. Addresses from 0x80000 upward are split into 0x80000-byte windows, one per link, and an access there is passed to the downstream side with a 3-bit link number and the 19-bit local offset.

Software brings a link up through its enable bit and then reaches that link's devices through its window. Several addresses have one meaning for reads and another for writes. A write to 0x18 sets enable bits, but a read of 0x18 returns the plug levels. A write to 0x1D0 resets the bridge, but a read of 0x1D0 returns the error status. The reset registers produce one-cycle strobes and never hold a value. Only one windowed access is outstanding at a time.

Top module: `hub_ctl_front`

## Requirements
- R1: After reset the mode, delay, enable and error-control state is zero, req_ready_o is 1, rsp_valid_o is 0 and every reset strobe is 0.
- R2: The mode register at 0x0 keeps only bits 31, 30, 28, 27:8 and 4 of a write, and the other bits read zero (write mask 0xDFFFFF10). The delay register at 0x4 keeps all 32 bits. Both are also driven on mode_o and dly_o.
- R3: The enable word at 0x10 is read/write. Link n is bit 31-n, and en_o[n] follows it. Bits for links at or above N_LINKS, and bits 23:0, read zero.
- R4: A write to 0x18 sets every enable bit whose data bit is 1, and a write to 0x20 clears every enable bit whose data bit is 1. All other enable bits keep their value. A read of 0x18 returns plug_i with link n at bit 31-n. A read of 0x20 returns zero.
- R5: The version word at 0x74 reads {16'h0, N_LINKS[7:0], HUB_REV}, and a write to it changes nothing.
- R6: A write to 0xD0 produces these one-cycle strobes in the cycle after the write edge: bit 29 drives rst_mst_o, bit 28 drives rst_lnk_o and bit 26 drives par_clr_o. Bit 27 clears mode, delay, enable and error control. A read of 0xD0 returns zero.
- R7: A read of 0x1D0 returns err_stat_i. A write to 0x1D0 strobes brg_gen_o from bit 31 and brg_err_o from bit 30 for one cycle.
- R8: Error control at 0x2E0 is write-only and reads zero. Bit 15 arms mchk_o, which is then high while mst_err_i is high. Bit 14 drives auto_term_o.
- R9: A request below 0x80000 is answered in the cycle after it is accepted. An address that matches no register answers with the error flag set and data zero, and changes no state.
- R10: A request at A >= 0x80000 is forwarded with dn_link_o = (A>>19)-1 and dn_addr_o = A[18:0], along with its write enable and data. dn_valid_o and its fields stay stable until dn_ready_i.
- R11: A windowed request whose link is at or above N_LINKS, or whose enable bit is 0, is answered with the error flag in the next cycle and is never forwarded.
- R12: A forwarded request is answered one cycle after dn_rsp_valid_i arrives following the downstream handshake, with dn_rdata_i and dn_err_i. req_ready_o stays 0 from acceptance until that answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Upstream request valid |
| req_ready_o | output | 1 | Upstream request can be accepted |
| req_addr_i | input | 32 | Request byte address |
| req_we_i | input | 1 | Request is a write |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_rdata_o | output | 32 | Response read data |
| rsp_err_o | output | 1 | Response error flag |
| dn_valid_o | output | 1 | Downstream request valid |
| dn_ready_i | input | 1 | Downstream request taken |
| dn_link_o | output | 3 | Target link number |
| dn_addr_o | output | 19 | Offset inside the link window |
| dn_we_o | output | 1 | Downstream write |
| dn_wdata_o | output | 32 | Downstream write data |
| dn_rsp_valid_i | input | 1 | Downstream response valid |
| dn_rdata_i | input | 32 | Downstream read data |
| dn_err_i | input | 1 | Downstream error |
| plug_i | input | N_LINKS | Plug level per link |
| err_stat_i | input | 32 | Master error status |
| mst_err_i | input | 1 | Master is in error |
| mode_o | output | 32 | Mode register contents |
| dly_o | output | 32 | Delay register contents |
| en_o | output | N_LINKS | Link enable per link |
| mchk_o | output | 1 | Machine-check request |
| auto_term_o | output | 1 | Auto-terminate enable |
| rst_mst_o | output | 1 | Reset-all-masters strobe |
| rst_lnk_o | output | 1 | Reset-all-link-controllers strobe |
| par_clr_o | output | 1 | Parity error clear strobe |
| brg_gen_o | output | 1 | Bridge general reset strobe |
| brg_err_o | output | 1 | Bridge error reset strobe |

## Verification
The bench targets the shared addresses. Reading 0x18 must return plug levels, not enables, so a design that returns the enable word fails as soon as the two vectors differ. The set and clear aliases are checked against links that are already set and already clear, which exposes a design that overwrites the whole word rather than touching only the selected bits. The window decode is checked at the first and last windows, at the offset just below the window base, at a link just past N_LINKS and at a disabled link. An off-by-one in the link arithmetic shows up as a forward on the wrong link. A missing enable check shows up as a forward where an error response was expected. The reset strobes are checked on the cycle after the write and on the cycle after that, which catches a design that holds them high or that leaves mode, delay, enable and error control untouched.

// File: rtl/hub_ctl_pkg.sv
package hub_ctl_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned AW        = 32;
  localparam int unsigned MAX_LINKS = 8;
  localparam int unsigned LINK_W    = 3;
  localparam int unsigned WIN_W     = 19;

  localparam logic [AW-1:0] OFS_MODE = 32'h0000_0000;
  localparam logic [AW-1:0] OFS_DLY  = 32'h0000_0004;
  localparam logic [AW-1:0] OFS_EN   = 32'h0000_0010;
  localparam logic [AW-1:0] OFS_SET  = 32'h0000_0018;
  localparam logic [AW-1:0] OFS_CLR  = 32'h0000_0020;
  localparam logic [AW-1:0] OFS_VER  = 32'h0000_0074;
  localparam logic [AW-1:0] OFS_PRST = 32'h0000_00D0;
  localparam logic [AW-1:0] OFS_BRG  = 32'h0000_01D0;
  localparam logic [AW-1:0] OFS_ECTL = 32'h0000_02E0;

  localparam logic [DW-1:0] MODE_WMASK = 32'hDFFF_FF10;

  localparam int unsigned PRST_MST  = 29;
  localparam int unsigned PRST_LNK  = 28;
  localparam int unsigned PRST_CTL  = 27;
  localparam int unsigned PRST_PAR  = 26;
  localparam int unsigned BRG_GEN   = 31;
  localparam int unsigned BRG_ERR   = 30;
  localparam int unsigned ECTL_MCHK = 15;
  localparam int unsigned ECTL_TERM = 14;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MODE, SEL_DLY, SEL_EN, SEL_SET, SEL_CLR,
    SEL_VER, SEL_PRST, SEL_BRG, SEL_ECTL
  } reg_sel_e;
endpackage

// File: rtl/hub_ctl_dec.sv
module hub_ctl_dec
  import hub_ctl_pkg::*;
#(
  parameter int unsigned N_LINKS = 8
) (
  input  logic [AW-1:0]     addr_i,
  output logic              win_o,
  output reg_sel_e          sel_o,
  output logic [LINK_W-1:0] link_o,
  output logic              in_range_o,
  output logic [WIN_W-1:0]  ofs_o
);
  localparam int unsigned SLOT_W = AW - WIN_W;

  logic [SLOT_W-1:0] slot, lidx;

  assign slot       = addr_i[AW-1:WIN_W];
  assign win_o      = (slot != '0);
  assign lidx       = slot - SLOT_W'(1);
  assign in_range_o = win_o && (lidx < SLOT_W'(N_LINKS));
  assign link_o     = lidx[LINK_W-1:0];
  assign ofs_o      = addr_i[WIN_W-1:0];

  always_comb begin
    case (addr_i)
      OFS_MODE: sel_o = SEL_MODE;
      OFS_DLY:  sel_o = SEL_DLY;
      OFS_EN:   sel_o = SEL_EN;
      OFS_SET:  sel_o = SEL_SET;
      OFS_CLR:  sel_o = SEL_CLR;
      OFS_VER:  sel_o = SEL_VER;
      OFS_PRST: sel_o = SEL_PRST;
      OFS_BRG:  sel_o = SEL_BRG;
      OFS_ECTL: sel_o = SEL_ECTL;
      default:  sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/hub_ctl_regs.sv
module hub_ctl_regs
  import hub_ctl_pkg::*;
#(
  parameter int unsigned N_LINKS = 8,
  parameter logic [7:0]  HUB_REV = 8'h01
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  reg_sel_e           sel_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [N_LINKS-1:0] plug_i,
  input  logic [DW-1:0]      err_stat_i,
  input  logic               mst_err_i,
  output logic [DW-1:0]      rdata_o,
  output logic               hit_o,
  output logic [N_LINKS-1:0] en_o,
  output logic [DW-1:0]      mode_o,
  output logic [DW-1:0]      dly_o,
  output logic               mchk_o,
  output logic               auto_term_o,
  output logic               rst_mst_o,
  output logic               rst_lnk_o,
  output logic               par_clr_o,
  output logic               brg_gen_o,
  output logic               brg_err_o
);
  localparam logic [7:0] LINK_CNT = 8'(N_LINKS);

  logic [DW-1:0]      mode_q, dly_q, en_word, plug_word;
  logic [N_LINKS-1:0] en_q, en_d, wlink;
  logic               mchk_arm_q, term_q, ctl_clr;

  // link n lives at bit DW-1-n of the word view
  for (genvar b = 0; b < DW; b++) begin : g_word
    if (b < N_LINKS) begin : g_link
      assign en_word[DW-1-b]   = en_q[b];
      assign plug_word[DW-1-b] = plug_i[b];
      assign wlink[b]          = wdata_i[DW-1-b];
    end else begin : g_pad
      assign en_word[DW-1-b]   = 1'b0;
      assign plug_word[DW-1-b] = 1'b0;
    end
  end

  assign ctl_clr = wr_i && (sel_i == SEL_PRST) && wdata_i[PRST_CTL];

  always_comb begin
    en_d = en_q;
    if (wr_i) begin
      case (sel_i)
        SEL_EN:  en_d = wlink;
        SEL_SET: en_d = en_q | wlink;
        SEL_CLR: en_d = en_q & ~wlink;
        default: en_d = en_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= '0;
      dly_q      <= '0;
      en_q       <= '0;
      mchk_arm_q <= 1'b0;
      term_q     <= 1'b0;
    end else if (ctl_clr) begin
      mode_q     <= '0;
      dly_q      <= '0;
      en_q       <= '0;
      mchk_arm_q <= 1'b0;
      term_q     <= 1'b0;
    end else begin
      en_q <= en_d;
      if (wr_i && sel_i == SEL_MODE) mode_q <= wdata_i & MODE_WMASK;
      if (wr_i && sel_i == SEL_DLY)  dly_q  <= wdata_i;
      if (wr_i && sel_i == SEL_ECTL) begin
        mchk_arm_q <= wdata_i[ECTL_MCHK];
        term_q     <= wdata_i[ECTL_TERM];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_mst_o <= 1'b0;
      rst_lnk_o <= 1'b0;
      par_clr_o <= 1'b0;
      brg_gen_o <= 1'b0;
      brg_err_o <= 1'b0;
    end else begin
      rst_mst_o <= wr_i && (sel_i == SEL_PRST) && wdata_i[PRST_MST];
      rst_lnk_o <= wr_i && (sel_i == SEL_PRST) && wdata_i[PRST_LNK];
      par_clr_o <= wr_i && (sel_i == SEL_PRST) && wdata_i[PRST_PAR];
      brg_gen_o <= wr_i && (sel_i == SEL_BRG)  && wdata_i[BRG_GEN];
      brg_err_o <= wr_i && (sel_i == SEL_BRG)  && wdata_i[BRG_ERR];
    end
  end

  always_comb begin
    case (sel_i)
      SEL_MODE: rdata_o = mode_q;
      SEL_DLY:  rdata_o = dly_q;
      SEL_EN:   rdata_o = en_word;
      SEL_SET:  rdata_o = plug_word;
      SEL_VER:  rdata_o = {16'h0000, LINK_CNT, HUB_REV};
      SEL_BRG:  rdata_o = err_stat_i;
      default:  rdata_o = '0;
    endcase
  end

  assign hit_o       = (sel_i != SEL_NONE);
  assign en_o        = en_q;
  assign mode_o      = mode_q;
  assign dly_o       = dly_q;
  assign auto_term_o = term_q;
  assign mchk_o      = mchk_arm_q & mst_err_i;

  // R4
  set_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_SET) |=> ((en_o & $past(en_o)) == $past(en_o)));
  // R4
  clr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_CLR) |=> ((en_o | $past(en_o)) == $past(en_o)));
  // R6
  ctl_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_PRST && wdata_i[PRST_CTL]) |=>
      (mode_o == '0 && dly_o == '0 && en_o == '0 && !auto_term_o));
endmodule

// File: rtl/hub_ctl_fwd.sv
module hub_ctl_fwd
  import hub_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LINK_W-1:0] link_i,
  input  logic [WIN_W-1:0]  ofs_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              dn_valid_o,
  input  logic              dn_ready_i,
  output logic [LINK_W-1:0] dn_link_o,
  output logic [WIN_W-1:0]  dn_addr_o,
  output logic              dn_we_o,
  output logic [DW-1:0]     dn_wdata_o,
  input  logic              dn_rsp_valid_i
);
  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fwd_st_e;

  fwd_st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= F_IDLE;
      dn_link_o  <= '0;
      dn_addr_o  <= '0;
      dn_we_o    <= 1'b0;
      dn_wdata_o <= '0;
    end else begin
      case (st_q)
        F_IDLE: if (start_i) begin
          st_q       <= F_REQ;
          dn_link_o  <= link_i;
          dn_addr_o  <= ofs_i;
          dn_we_o    <= we_i;
          dn_wdata_o <= wdata_i;
        end
        F_REQ:   if (dn_ready_i) st_q <= F_WAIT;
        F_WAIT:  if (dn_rsp_valid_i) st_q <= F_IDLE;
        default: st_q <= F_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != F_IDLE);
  assign dn_valid_o = (st_q == F_REQ);
  assign done_o     = (st_q == F_WAIT) && dn_rsp_valid_i;

  // R10
  dn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_valid_o && !dn_ready_i) |=> (dn_valid_o && $stable(dn_addr_o) &&
      $stable(dn_link_o) && $stable(dn_we_o) && $stable(dn_wdata_o)));
endmodule

// File: rtl/hub_ctl_front.sv
module hub_ctl_front
  import hub_ctl_pkg::*;
#(
  parameter int unsigned N_LINKS = 8,
  parameter logic [7:0]  HUB_REV = 8'h01
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [31:0]        req_addr_i,
  input  logic               req_we_i,
  input  logic [31:0]        req_wdata_i,
  output logic               rsp_valid_o,
  output logic [31:0]        rsp_rdata_o,
  output logic               rsp_err_o,
  output logic               dn_valid_o,
  input  logic               dn_ready_i,
  output logic [2:0]         dn_link_o,
  output logic [18:0]        dn_addr_o,
  output logic               dn_we_o,
  output logic [31:0]        dn_wdata_o,
  input  logic               dn_rsp_valid_i,
  input  logic [31:0]        dn_rdata_i,
  input  logic               dn_err_i,
  input  logic [N_LINKS-1:0] plug_i,
  input  logic [31:0]        err_stat_i,
  input  logic               mst_err_i,
  output logic [31:0]        mode_o,
  output logic [31:0]        dly_o,
  output logic [N_LINKS-1:0] en_o,
  output logic               mchk_o,
  output logic               auto_term_o,
  output logic               rst_mst_o,
  output logic               rst_lnk_o,
  output logic               par_clr_o,
  output logic               brg_gen_o,
  output logic               brg_err_o
);
  logic              win, in_range, hit, busy, fwd_done, accept, link_ok, fwd_start;
  reg_sel_e          sel;
  logic [LINK_W-1:0] link;
  logic [WIN_W-1:0]  ofs;
  logic [DW-1:0]     reg_rdata;
  logic [MAX_LINKS-1:0] en_pad;
  logic              rsp_valid_q, rsp_err_q;
  logic [DW-1:0]     rsp_rdata_q;

  hub_ctl_dec #(.N_LINKS(N_LINKS)) u_dec (
    .addr_i(req_addr_i), .win_o(win), .sel_o(sel), .link_o(link),
    .in_range_o(in_range), .ofs_o(ofs)
  );

  assign req_ready_o = !busy;
  assign accept      = req_valid_i && req_ready_o;
  assign en_pad      = MAX_LINKS'(en_o);
  assign link_ok     = in_range && en_pad[link];
  assign fwd_start   = accept && link_ok;

  hub_ctl_regs #(.N_LINKS(N_LINKS), .HUB_REV(HUB_REV)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(accept && req_we_i && !win), .sel_i(sel), .wdata_i(req_wdata_i),
    .plug_i, .err_stat_i, .mst_err_i,
    .rdata_o(reg_rdata), .hit_o(hit), .en_o, .mode_o, .dly_o,
    .mchk_o, .auto_term_o, .rst_mst_o, .rst_lnk_o, .par_clr_o,
    .brg_gen_o, .brg_err_o
  );

  hub_ctl_fwd u_fwd (
    .clk_i, .rst_ni,
    .start_i(fwd_start), .link_i(link), .ofs_i(ofs), .we_i(req_we_i),
    .wdata_i(req_wdata_i), .busy_o(busy), .done_o(fwd_done),
    .dn_valid_o, .dn_ready_i, .dn_link_o, .dn_addr_o, .dn_we_o,
    .dn_wdata_o, .dn_rsp_valid_i
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      rsp_err_q   <= 1'b0;
    end else begin
      rsp_valid_q <= (accept && !fwd_start) || fwd_done;
      if (fwd_done) begin
        rsp_rdata_q <= dn_rdata_i;
        rsp_err_q   <= dn_err_i;
      end else if (accept) begin
        rsp_rdata_q <= (!win && !req_we_i && hit) ? reg_rdata : '0;
        rsp_err_q   <= win || !hit;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign rsp_err_o   = rsp_err_q;

  // R9
  reg_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !win) |=> rsp_valid_o);
  // R11
  bad_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && win && !link_ok) |=> (rsp_valid_o && rsp_err_o && !dn_valid_o));
  // R11
  fwd_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o |-> (en_pad[dn_link_o] && (32'(dn_link_o) < N_LINKS)));
  // R12
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o |-> !req_ready_o);
endmodule

// File: tb/sim_hub_ctl_front.sv
module sim_hub_ctl_front;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_we = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic dn_valid, dn_ready = 0, dn_we, dn_rsp_valid = 0, dn_err = 0;
  logic [2:0] dn_link;
  logic [18:0] dn_addr;
  logic [31:0] dn_wdata, dn_rdata = 0;
  logic [NL-1:0] plug = 0, en;
  logic [31:0] err_stat = 0, mode, dly;
  logic mst_err = 0, mchk, aterm, s_mst, s_lnk, s_par, s_gen, s_err;

  int n_tests = 0, n_fail = 0, fwd_cnt = 0;
  bit done = 0;
  logic [31:0] exp_d[$];
  logic        exp_e[$];
  string       exp_tag[$];
  logic [2:0]  xf_link;
  logic [18:0] xf_ofs;
  logic        xf_we;
  logic [31:0] xf_wd;
  bit          dn_phase = 0;
  logic [2:0]  lat_link;
  logic [18:0] lat_ofs;

  always #(CLK_PERIOD/2) clk = ~clk;

  hub_ctl_front #(.N_LINKS(NL), .HUB_REV(8'h3C)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_we_i(req_we), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .dn_valid_o(dn_valid), .dn_ready_i(dn_ready), .dn_link_o(dn_link),
    .dn_addr_o(dn_addr), .dn_we_o(dn_we), .dn_wdata_o(dn_wdata),
    .dn_rsp_valid_i(dn_rsp_valid), .dn_rdata_i(dn_rdata), .dn_err_i(dn_err),
    .plug_i(plug), .err_stat_i(err_stat), .mst_err_i(mst_err),
    .mode_o(mode), .dly_o(dly), .en_o(en), .mchk_o(mchk), .auto_term_o(aterm),
    .rst_mst_o(s_mst), .rst_lnk_o(s_lnk), .par_clr_o(s_par),
    .brg_gen_o(s_gen), .brg_err_o(s_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dn_model_data(input logic [2:0] l, input logic [18:0] o);
    return {8'hA5, 2'b00, l, o};
  endfunction

  // driver: pushes expected response, then issues the request
  task automatic access(input logic [31:0] a, input bit we, input logic [31:0] wd,
                        input logic [31:0] ed, input bit ee, input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_d.push_back(ed); exp_e.push_back(ee); exp_tag.push_back(tag);
    req_valid = 1; req_addr = a; req_we = we; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_we = 0;
  endtask

  task automatic wait_idle();
    while (exp_d.size() != 0 || !req_ready) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_d.size() == 0) chk(0, "R9 unsolicited response", rsp_rdata, 0);
      else begin
        logic [31:0] d; logic e; string t;
        d = exp_d.pop_front(); e = exp_e.pop_front(); t = exp_tag.pop_front();
        chk(rsp_rdata == d && rsp_err == e, t, {rsp_err, rsp_rdata[30:0]}, {e, d[30:0]});
        if (rsp_rdata != d) $display("     data act=%h exp=%h", rsp_rdata, d);
      end
    end
  end

  // downstream link model
  always @(negedge clk) begin
    dn_ready = 0; dn_rsp_valid = 0;
    if (rst_n) begin
      if (dn_phase) begin
        dn_rsp_valid = 1;
        dn_rdata = dn_model_data(lat_link, lat_ofs);
        dn_err = (lat_ofs == 19'h7FFFC);
        dn_phase = 0;
      end else if (dn_valid) begin
        fwd_cnt++;
        chk(dn_link == xf_link && dn_addr == xf_ofs, "R10 link/offset",
            {10'h0, dn_link, dn_addr}, {10'h0, xf_link, xf_ofs});
        chk(dn_we == xf_we && dn_wdata == xf_wd, "R10 we/data", dn_wdata, xf_wd);
        chk(!req_ready, "R12 ready low while forwarding", {31'h0, req_ready}, 0);
        lat_link = dn_link; lat_ofs = dn_addr;
        dn_ready = 1; dn_phase = 1;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int fc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(mode == 0 && dly == 0 && en == 0 && !aterm && !mchk, "R1 reset state", mode, 0);
    chk(req_ready && !rsp_valid && !dn_valid, "R1 idle handshake", {30'h0, req_ready, rsp_valid}, 32'h2);
    chk({s_mst, s_lnk, s_par, s_gen, s_err} == 0, "R1 strobes low", {27'h0, s_mst, s_lnk, s_par, s_gen, s_err}, 0);

    // R5
    access(32'h74, 0, 0, 32'h0000_063C, 0, "R5 version read");
    access(32'h74, 1, 32'hFFFF_FFFF, 0, 0, "R5 version write");
    access(32'h74, 0, 0, 32'h0000_063C, 0, "R5 version unchanged");

    // R2
    access(32'h0, 1, 32'hFFFF_FFFF, 0, 0, "R2 mode write");
    access(32'h0, 0, 0, 32'hDFFF_FF10, 0, "R2 mode mask");
    chk(mode == 32'hDFFF_FF10, "R2 mode_o", mode, 32'hDFFF_FF10);
    access(32'h4, 1, 32'hFFFF_0000, 0, 0, "R2 delay write");
    access(32'h4, 0, 0, 32'hFFFF_0000, 0, "R2 delay read");

    // R3
    access(32'h10, 1, 32'hFFFF_FFFF, 0, 0, "R3 enable write");
    access(32'h10, 0, 0, 32'hFC00_0000, 0, "R3 unimplemented bits zero");
    chk(en == 6'h3F, "R3 en_o", {26'h0, en}, 32'h3F);

    // R4
    access(32'h20, 1, 32'h8400_0000, 0, 0, "R4 clear alias");
    access(32'h10, 0, 0, 32'h7800_0000, 0, "R4 clear result");
    chk(en == 6'b011110, "R4 en_o after clear", {26'h0, en}, 32'h1E);
    access(32'h18, 1, 32'h8800_0000, 0, 0, "R4 set alias");
    access(32'h10, 0, 0, 32'hF800_0000, 0, "R4 set keeps others");
    plug = 6'b000101;
    access(32'h18, 0, 0, 32'hA000_0000, 0, "R4 read 0x18 is plug level");
    access(32'h20, 0, 0, 32'h0, 0, "R4 read 0x20 zero");

    // R8
    access(32'h2E0, 1, 32'h0000_C000, 0, 0, "R8 ectl write");
    chk(aterm, "R8 auto_term_o", {31'h0, aterm}, 1);
    chk(!mchk, "R8 mchk low without error", {31'h0, mchk}, 0);
    mst_err = 1; #1;
    chk(mchk, "R8 mchk with error", {31'h0, mchk}, 1);
    mst_err = 0; #1;
    chk(!mchk, "R8 mchk drops", {31'h0, mchk}, 0);
    access(32'h2E0, 0, 0, 32'h0, 0, "R8 ectl reads zero");

    // R7
    err_stat = 32'h1234_5678;
    access(32'h1D0, 0, 0, 32'h1234_5678, 0, "R7 error status read");
    access(32'h1D0, 1, 32'hC000_0000, 0, 0, "R7 bridge reset write");
    chk(s_gen && s_err, "R7 bridge strobes", {30'h0, s_gen, s_err}, 3);
    @(negedge clk);
    chk(!s_gen && !s_err, "R7 bridge strobes self-clear", {30'h0, s_gen, s_err}, 0);

    // R6
    access(32'hD0, 1, 32'h3400_0000, 0, 0, "R6 port reset strobes");
    chk(s_mst && s_lnk && s_par, "R6 strobes high", {29'h0, s_mst, s_lnk, s_par}, 7);
    chk(mode == 32'hDFFF_FF10, "R6 mode kept without bit 27", mode, 32'hDFFF_FF10);
    @(negedge clk);
    chk(!s_mst && !s_lnk && !s_par, "R6 strobes self-clear", {29'h0, s_mst, s_lnk, s_par}, 0);
    access(32'hD0, 0, 0, 32'h0, 0, "R6 reset reg reads zero");
    access(32'hD0, 1, 32'h0800_0000, 0, 0, "R6 control clear");
    chk(mode == 0 && dly == 0 && en == 0 && !aterm, "R6 control regs cleared", mode | dly, 0);
    access(32'h10, 0, 0, 32'h0, 0, "R6 enable read after clear");

    // R9
    access(32'h8, 0, 0, 32'h0, 1, "R9 unmapped read");
    access(32'h100, 1, 32'hFFFF_FFFF, 0, 1, "R9 unmapped write");
    access(32'h7_FFFC, 0, 0, 32'h0, 1, "R9 just below window");
    access(32'h10, 0, 0, 32'h0, 0, "R9 no state change");

    // R10 / R12
    access(32'h18, 1, 32'hFC00_0000, 0, 0, "R4 enable all");
    xf_link = 3'd2; xf_ofs = 19'h01234; xf_we = 0; xf_wd = 0;
    access(32'h0018_1234, 0, 0, dn_model_data(3'd2, 19'h01234), 0, "R12 window read link 2");
    wait_idle();
    xf_link = 3'd0; xf_ofs = 19'h00000; xf_we = 1; xf_wd = 32'hDEAD_BEEF;
    access(32'h0008_0000, 1, 32'hDEAD_BEEF, dn_model_data(3'd0, 19'h0), 0, "R10 window write link 0");
    wait_idle();
    xf_link = 3'd5; xf_ofs = 19'h7FFFC; xf_we = 0; xf_wd = 0;
    access(32'h0037_FFFC, 0, 0, dn_model_data(3'd5, 19'h7FFFC), 1, "R12 downstream error link 5");
    wait_idle();
    chk(fwd_cnt == 3, "R10 forward count", fwd_cnt, 3);

    // R11
    fc = fwd_cnt;
    access(32'h0038_0000, 0, 0, 32'h0, 1, "R11 link beyond count");
    access(32'h0048_0000, 1, 32'h1, 32'h0, 1, "R11 slot beyond 3-bit range");
    access(32'h20, 1, 32'h1000_0000, 0, 0, "R4 clear link 3");
    access(32'h0020_0010, 0, 0, 32'h0, 1, "R11 disabled link");
    wait_idle();
    repeat (3) @(negedge clk);
    chk(fwd_cnt == fc, "R11 nothing forwarded", fwd_cnt, fc);

    wait_idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule